// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a successive-approximation A/D converter. It takes a register-style start bit and a power-off bit, and it forms a conversion-rate strobe from the system clock through a 3-bit selectable prescaler. It then walks a 12-bit trial code from the most significant bit down to the least, one decision per strobe period, using a single comparator input. The analog comparator, the DAC that turns the trial code into a voltage and the sample-and-hold all sit outside the block.

A conversion starts only when software raises the start bit and then lowers it. While the bit stays high the sequencer is held in reset with its active-low done flag high. Completion is reported by that flag dropping, by a sticky interrupt flag, and by a one-cycle interrupt pulse that is gated by an enable input. Two prescaler codes are reserved. A status flag warns when the selected rate gives a strobe period shorter than the allowed minimum for the configured system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, eoc_n_o is 1, trial_o and result_o are 0, and irq_o and irq_flag_o are 0.
- R2: Holding start_i high, for any number of cycles, keeps eoc_n_o at 1 and trial_o at 0. A conversion is launched only at the first clock edge that samples start_i low after it was sampled high.
- R3: div_sel_i selects the strobe divisor: 3'b100→1, 3'b000→2, 3'b101→4, 3'b001→8, 3'b110→16, 3'b010→32. A conversion takes one sampling period and then 12 bit periods, each one divisor long, so eoc_n_o falls exactly 13×divisor cycles after the launch edge.
- R4: Each bit period sets its trial bit. At the end of the period the bit is kept if cmp_i is 1 (input at or above the trial level) and cleared if cmp_i is 0, working from bit 11 down to bit 0.
- R5: result_o takes the final code at the same edge at which eoc_n_o falls, and changes at no other time.
- R6: At completion, irq_flag_o is set and stays set until irq_clr_i is sampled high. irq_o pulses for one cycle at completion only if irq_en_i was high.
- R7: Codes 3'b011 and 3'b111 are reserved. sel_err_o is 1 one cycle after such a code is applied. A start sequence under a reserved code launches nothing, and a reserved code applied during a conversion aborts it, with eoc_n_o left at 1.
- R8: With pwr_off_i high no conversion is launched, and raising pwr_off_i during a conversion aborts it, with eoc_n_o left at 1.
- R9: too_fast_o is 1, one cycle after the code is applied, when divisor × 10^6 / SYS_FREQ_KHZ ns is below MIN_PERIOD_NS. With the defaults (8000 kHz, 500 ns) this holds for divisors 1 and 2 only, and is 0 for reserved codes.
- R10: A new start sequence during a conversion abandons it without completing it, and a fresh conversion with full timing follows from the new launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start bit: high holds reset, falling launches |
| pwr_off_i | input | 1 | High powers the converter down |
| div_sel_i | input | 3 | Prescaler select code |
| cmp_i | input | 1 | Comparator result for the current trial code |
| irq_en_i | input | 1 | Interrupt pulse enable |
| irq_clr_i | input | 1 | Clears the sticky interrupt flag |
| trial_o | output | 12 | Trial code for the DAC |
| result_o | output | 12 | Last completed conversion result |
| eoc_n_o | output | 1 | Active-low end-of-conversion flag |
| irq_flag_o | output | 1 | Sticky interrupt request flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| sel_err_o | output | 1 | Reserved prescaler code selected |
| too_fast_o | output | 1 | Selected strobe period below the minimum |

## Verification
The hardest cases to reach are a conversion abandoned partway through, whether by a new start sequence, a reserved code or power-down, because the evidence is only that nothing happens. The bench models the comparator as a fixed analog level that it compares against trial_o. It lets a conversion run for a chosen number of cycles, then disturbs it. The scoreboard expects either no completion at all or only the second conversion's value at a latency counted from the second launch edge, and any unqueued fall of eoc_n_o counts as an error.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    localparam int SEL_W   = 3;
    localparam int DIV_W   = 6;
    localparam int MAX_DIV = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;

    // Divisor for each select code; zero marks a reserved code.
    function automatic logic [DIV_W-1:0] div_of(input logic [SEL_W-1:0] code);
        case (code)
            3'b100:  return 6'd1;
            3'b000:  return 6'd2;
            3'b101:  return 6'd4;
            3'b001:  return 6'd8;
            3'b110:  return 6'd16;
            3'b010:  return 6'd32;
            default: return 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/adc_div_decode.sv
`timescale 1ns/1ps
module adc_div_decode
    import adc_seq_pkg::*;
#(
    parameter int unsigned SYS_FREQ_KHZ  = 8000,
    parameter int unsigned MIN_PERIOD_NS = 500
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [DIV_W-1:0] div_o,
    output logic             reserved_o,
    output logic             too_fast_o
);

    localparam int     NCODES = 1 << SEL_W;
    localparam longint LIMIT  = longint'(MIN_PERIOD_NS) * longint'(SYS_FREQ_KHZ);

    logic [NCODES-1:0] fast_tbl;

    for (genvar i = 0; i < NCODES; i++) begin : g_code
        localparam longint DIV_I = longint'(div_of(SEL_W'(i)));
        // period_ns = div * 1e6 / f_khz; compare without division
        assign fast_tbl[i] = (DIV_I != 0) && ((DIV_I * 64'd1000000) < LIMIT);
    end

    always_comb begin
        div_o      = div_of(sel_i);
        reserved_o = (div_o == '0);
        too_fast_o = fast_tbl[sel_i];
    end

endmodule

// File: rtl/adc_prescaler.sv
`timescale 1ns/1ps
module adc_prescaler
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = $clog2(MAX_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && ({{(DIV_W-CNT_W){1'b0}}, cnt_q} == (div_i - DIV_W'(1)));
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int          RES_W         = 12,
    parameter int unsigned SYS_FREQ_KHZ  = 8000,
    parameter int unsigned MIN_PERIOD_NS = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pwr_off_i,
    input  logic [2:0]       div_sel_i,
    input  logic             cmp_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] result_o,
    output logic             eoc_n_o,
    output logic             irq_flag_o,
    output logic             irq_o,
    output logic             sel_err_o,
    output logic             too_fast_o
);

    localparam int BIT_W = $clog2(RES_W);

    typedef struct packed {
        seq_state_e       st;
        logic             start;
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] result;
        logic [BIT_W-1:0] bidx;
        logic             eoc_n;
        logic             flag;
        logic             irq;
        logic             sel_err;
        logic             fast;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DIV_W-1:0] div;
    logic             reserved;
    logic             fast;
    logic             tick;
    logic             fall;
    logic [RES_W-1:0] decided;

    adc_div_decode #(
        .SYS_FREQ_KHZ (SYS_FREQ_KHZ),
        .MIN_PERIOD_NS(MIN_PERIOD_NS)
    ) u_dec (
        .sel_i     (div_sel_i),
        .div_o     (div),
        .reserved_o(reserved),
        .too_fast_o(fast)
    );

    adc_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (ctl_q.st != ST_IDLE),
        .div_i (div),
        .tick_o(tick)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.start   = start_i;
        ctl_d.irq     = 1'b0;
        ctl_d.sel_err = reserved;
        ctl_d.fast    = fast;
        if (irq_clr_i) begin
            ctl_d.flag = 1'b0;
        end

        fall    = ctl_q.start && !start_i;
        decided = ctl_q.trial;
        if (!cmp_i) begin
            decided[ctl_q.bidx] = 1'b0;
        end

        if (start_i) begin
            // raised start bit holds the sequencer in reset
            ctl_d.st    = ST_IDLE;
            ctl_d.trial = '0;
            ctl_d.eoc_n = 1'b1;
        end else if (pwr_off_i || reserved) begin
            ctl_d.st    = ST_IDLE;
            ctl_d.trial = '0;
        end else if (fall) begin
            ctl_d.st    = ST_SAMPLE;
            ctl_d.trial = '0;
            ctl_d.eoc_n = 1'b1;
        end else begin
            case (ctl_q.st)
                ST_SAMPLE: begin
                    if (tick) begin
                        ctl_d.st           = ST_CONV;
                        ctl_d.bidx         = BIT_W'(RES_W - 1);
                        ctl_d.trial        = '0;
                        ctl_d.trial[RES_W-1] = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        if (ctl_q.bidx == '0) begin
                            ctl_d.st     = ST_IDLE;
                            ctl_d.result = decided;
                            ctl_d.trial  = '0;
                            ctl_d.eoc_n  = 1'b0;
                            ctl_d.flag   = 1'b1;
                            ctl_d.irq    = irq_en_i;
                        end else begin
                            ctl_d.trial = decided;
                            ctl_d.trial[ctl_q.bidx - BIT_W'(1)] = 1'b1;
                            ctl_d.bidx  = ctl_q.bidx - BIT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= ST_IDLE;
            ctl_q.eoc_n   <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign trial_o    = ctl_q.trial;
    assign result_o   = ctl_q.result;
    assign eoc_n_o    = ctl_q.eoc_n;
    assign irq_flag_o = ctl_q.flag;
    assign irq_o      = ctl_q.irq;
    assign sel_err_o  = ctl_q.sel_err;
    assign too_fast_o = ctl_q.fast;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             pwr_off_i,
    input logic             irq_en_i,
    input logic             irq_clr_i,
    input logic [RES_W-1:0] trial_o,
    input logic [RES_W-1:0] result_o,
    input logic             eoc_n_o,
    input logic             irq_flag_o,
    input logic             irq_o,
    input logic             sel_err_o
);

    // R2: a sampled-high start bit leaves the sequencer in reset
    a_r2_start_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (eoc_n_o && (trial_o == '0)));

    // R5: the result moves only together with the done flag falling
    a_r5_result_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(eoc_n_o) |-> $stable(result_o));

    // R6: pulse requires enable and the flag, and lasts one cycle
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(irq_en_i) && irq_flag_o));

    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r6_flag_clear_only_by_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag_o) |-> $past(irq_clr_i));

    // R7: completion never happens under a reserved code
    a_r7_done_needs_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n_o) |-> !sel_err_o);

    // R8: completion never happens while powered down
    a_r8_done_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n_o) |-> !$past(pwr_off_i));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pwr_off_i (pwr_off_i),
    .irq_en_i  (irq_en_i),
    .irq_clr_i (irq_clr_i),
    .trial_o   (trial_o),
    .result_o  (result_o),
    .eoc_n_o   (eoc_n_o),
    .irq_flag_o(irq_flag_o),
    .irq_o     (irq_o),
    .sel_err_o (sel_err_o)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

    localparam int RES_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             pwr_off_i = 1'b0;
    logic [2:0]       div_sel_i = 3'b001;
    logic             cmp_i;
    logic             irq_en_i = 1'b0;
    logic             irq_clr_i = 1'b0;
    logic [RES_W-1:0] trial_o;
    logic [RES_W-1:0] result_o;
    logic             eoc_n_o;
    logic             irq_flag_o;
    logic             irq_o;
    logic             sel_err_o;
    logic             too_fast_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int vin = 0;
    int last_res = 0;

    typedef struct {
        int value;
        int done_cyc;
        bit irq;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // comparator model: high when the analog level is at or above the trial
    assign cmp_i = (int'(trial_o) <= vin);

    adc_seq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .pwr_off_i (pwr_off_i),
        .div_sel_i (div_sel_i),
        .cmp_i     (cmp_i),
        .irq_en_i  (irq_en_i),
        .irq_clr_i (irq_clr_i),
        .trial_o   (trial_o),
        .result_o  (result_o),
        .eoc_n_o   (eoc_n_o),
        .irq_flag_o(irq_flag_o),
        .irq_o     (irq_o),
        .sel_err_o (sel_err_o),
        .too_fast_o(too_fast_o)
    );

    function automatic int div_ref(input logic [2:0] c);
        case (c)
            3'b100: return 1;
            3'b000: return 2;
            3'b101: return 4;
            3'b001: return 8;
            3'b110: return 16;
            3'b010: return 32;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: every fall of the done flag must match a queued item
    logic prev_eoc = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_eoc <= 1'b1;
        end else begin
            if (prev_eoc && !eoc_n_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected completion", int'(result_o), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(result_o) == e.value, "R4 result", int'(result_o), e.value);
                    chk(cyc == e.done_cyc, "R3 latency", cyc, e.done_cyc);
                    chk(irq_o == e.irq, "R6 irq pulse", int'(irq_o), int'(e.irq));
                    chk(irq_flag_o == 1'b1, "R6 flag set", int'(irq_flag_o), 1);
                    last_res = int'(result_o);
                end
            end
            prev_eoc <= eoc_n_o;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    task automatic launch(input logic [2:0] code, input int v, input bit en, input bit push);
        @(negedge clk);
        div_sel_i = code;
        vin       = v;
        irq_en_i  = en;
        start_i   = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        if (push) begin
            sb.push_back('{v, cyc + 1 + 13 * div_ref(code), en});
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 5000 && sb.size() != 0; i++) @(negedge clk);
        chk(sb.size() == 0, "R3 completion seen", sb.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(eoc_n_o == 1'b1, "R1 eoc_n", int'(eoc_n_o), 1);
        chk(trial_o == '0 && result_o == '0, "R1 codes", int'(result_o), 0);
        chk(!irq_o && !irq_flag_o, "R1 irq", int'(irq_flag_o), 0);

        // R2 start held high for a long time
        div_sel_i = 3'b100;
        start_i   = 1'b1;
        repeat (60) @(negedge clk);
        chk(eoc_n_o == 1'b1 && trial_o == '0, "R2 held high", int'(trial_o), 0);
        start_i = 1'b0;
        sb.push_back('{0, cyc + 1 + 13, 1'b0});
        drain();

        // R3/R4/R5 every divisor with distinct levels
        launch(3'b100, 12'hA5A, 1'b1, 1'b1); drain();
        launch(3'b000, 12'hFFF, 1'b1, 1'b1); drain();
        launch(3'b101, 12'h800, 1'b0, 1'b1); drain();
        launch(3'b001, 12'h7FF, 1'b1, 1'b1); drain();
        launch(3'b110, 12'h001, 1'b0, 1'b1); drain();
        launch(3'b010, 12'h35C, 1'b1, 1'b1); drain();

        // R6 sticky flag until cleared
        repeat (20) @(negedge clk);
        chk(irq_flag_o == 1'b1, "R6 flag sticky", int'(irq_flag_o), 1);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        chk(irq_flag_o == 1'b0, "R6 flag cleared", int'(irq_flag_o), 0);
        launch(3'b101, 12'h123, 1'b0, 1'b1); drain();
        chk(irq_flag_o == 1'b1 && irq_o == 1'b0, "R6 flag without pulse", int'(irq_o), 0);

        // R9 too-fast flag per code
        for (int c = 0; c < 8; c++) begin
            int d;
            @(negedge clk);
            div_sel_i = 3'(c);
            @(negedge clk);
            d = div_ref(3'(c));
            chk(too_fast_o == (d == 1 || d == 2), "R9 too_fast", int'(too_fast_o), int'(d == 1 || d == 2));
            chk(sel_err_o == (d == 0), "R7 sel_err", int'(sel_err_o), int'(d == 0));
        end

        // R7 reserved code: no launch, and abort mid-conversion
        launch(3'b011, 12'h456, 1'b1, 1'b0);
        repeat (500) @(negedge clk);
        chk(eoc_n_o == 1'b1 && int'(result_o) == last_res, "R7 reserved no launch", int'(result_o), last_res);
        launch(3'b001, 12'h456, 1'b1, 1'b0);
        repeat (30) @(negedge clk);
        div_sel_i = 3'b111;
        repeat (200) @(negedge clk);
        chk(eoc_n_o == 1'b1 && trial_o == '0, "R7 reserved abort", int'(trial_o), 0);

        // R8 power-down: no launch, and abort mid-conversion
        pwr_off_i = 1'b1;
        launch(3'b001, 12'h789, 1'b1, 1'b0);
        repeat (200) @(negedge clk);
        chk(eoc_n_o == 1'b1 && int'(result_o) == last_res, "R8 off no launch", int'(result_o), last_res);
        pwr_off_i = 1'b0;
        launch(3'b001, 12'h789, 1'b1, 1'b0);
        repeat (50) @(negedge clk);
        pwr_off_i = 1'b1;
        repeat (200) @(negedge clk);
        chk(eoc_n_o == 1'b1 && trial_o == '0, "R8 off abort", int'(trial_o), 0);
        pwr_off_i = 1'b0;

        // R10 restart during a conversion
        launch(3'b001, 12'hAAA, 1'b1, 1'b0);
        repeat (40) @(negedge clk);
        launch(3'b001, 12'h555, 1'b1, 1'b1);
        drain();
        repeat (200) @(negedge clk);
        chk(int'(result_o) == 12'h555, "R10 restart result", int'(result_o), 12'h555);

        finish_run();
    end

endmodule